// File: doc/BRIEF.md
# Chained Debug Trigger Evaluator

This block keeps the settings of ten hardware debug triggers and tests them against the machine's traffic on every clock. Each trigger watches one fixed kind of address: the instruction fetch PC, the load address or the store address. It compares that address with a 64-bit value it holds. The comparison can be equal, unsigned greater-or-equal, or unsigned less-than. Settings arrive one trigger at a time on a write port that carries a valid bit.

The triggers sit in pairs, and each pair has a fixed type. A chain setting on the even member of a pair turns the two into one condition. A chained pair fires only when both members match in the same cycle and both ask for the same trap timing. Timing 0 asks for a trap on the current instruction and timing 1 asks for a trap on the next one. The block reports which triggers fired, plus one flag for each timing. These outputs come from a register and appear one cycle after the addresses they describe.

Top module: `dtrig_eval`

## Requirements
- R1: After reset every trigger is unarmed, all outputs are 0, and no trigger fires until it has been written, whatever the address inputs carry.
- R2: A write with `cfg_wr_valid` high and `cfg_wr_idx` in 0..9 replaces that trigger's settings and arms it. The new settings apply to addresses presented from the next cycle on, not the cycle of the write. A write with index 10..15 changes no trigger.
- R3: Match type `cfg_wr_mtype` selects the comparison between the watched address and the stored value: 0 is equal, 2 is unsigned greater-or-equal, 3 is unsigned less-than. Type 1 never matches.
- R4: Triggers 0, 1, 6 and 8 watch the fetch PC. Triggers 2, 3 and 7 watch the store address. Triggers 4, 5 and 9 watch the load address. A trigger can match only in a cycle where its source's valid bit is high.
- R5: A trigger written with `cfg_wr_select` = 1 asks for a data-value comparison, which the block cannot do, so that trigger never fires.
- R6: The chain bit written to trigger 2g controls pair g (triggers 2g and 2g+1). The chain bit written to an odd trigger has no effect. A trigger in an unchained pair fires on its own match.
- R7: A chained pair fires both bits only when both members match in the same cycle and have equal timing bits. Otherwise neither member fires.
- R8: Pair 1 (triggers 2 and 3, both watching stores) never fires while it is chained.
- R9: `fire_now` is the OR of fired triggers whose timing bit is 0, and `fire_next` is the OR of fired triggers whose timing bit is 1.
- R10: `fire_vec`, `fire_now` and `fire_next` are registered. They show the result for the addresses present before the rising edge that loads them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_valid | input | 1 | Write strobe for trigger settings |
| cfg_wr_idx | input | 4 | Index of the trigger written |
| cfg_wr_mtype | input | 2 | Comparison type |
| cfg_wr_select | input | 1 | 1 requests a data-value comparison |
| cfg_wr_timing | input | 1 | 0 traps on the current instruction, 1 on the next |
| cfg_wr_chain | input | 1 | Chain bit (used only on even triggers) |
| cfg_wr_value | input | ADDR_W | Compare value |
| fetch_valid | input | 1 | Fetch PC is valid |
| fetch_pc | input | ADDR_W | Instruction fetch PC |
| load_valid | input | 1 | Load address is valid |
| load_addr | input | ADDR_W | Load address |
| store_valid | input | 1 | Store address is valid |
| store_addr | input | ADDR_W | Store address |
| fire_vec | output | 10 | Per-trigger fire bits |
| fire_now | output | 1 | A fired trigger asks for a trap on this instruction |
| fire_next | output | 1 | A fired trigger asks for a trap on the next instruction |

## Verification
The bench drives the fetch PC at a stored value in the same cycle the value is written. A design that applied settings too early would fire there. It steps addresses across each comparison boundary, where an off-by-one or signed comparison flips the result. It also drives a chained pair in three ways: only one member matches, the members' timings differ, and the pair is the store-store pair. A design that resolved chaining per trigger would let a lone member fire in these cases. The bench also writes out-of-range indices and the chain bit of odd triggers, where a design that decoded too loosely would disturb other triggers.

// File: rtl/dtrig_pkg.sv
// Package: shared constants, settings record and fixed pair layout of the
// debug trigger evaluator. Assumes exactly five pairs of triggers.
package dtrig_pkg;

    localparam int unsigned PAIR_NUM   = 5;
    localparam int unsigned TRIG_NUM   = 2 * PAIR_NUM;
    localparam int unsigned TRIG_IDX_W = $clog2(TRIG_NUM + 1);

    // Address source watched by a trigger.
    typedef enum logic [1:0] {
        SRC_FETCH = 2'd0,
        SRC_LOAD  = 2'd1,
        SRC_STORE = 2'd2
    } src_e;

    // Comparison kind applied between watched address and stored value.
    typedef enum logic [1:0] {
        MT_EQ   = 2'd0,
        MT_NONE = 2'd1,
        MT_GE   = 2'd2,
        MT_LT   = 2'd3
    } mtype_e;

    // Per-trigger settings apart from the compare value and chain bit.
    typedef struct packed {
        logic   armed;
        mtype_e mtype;
        logic   sel;
        logic   timing;
    } tctl_t;

    // Fixed source of each trigger: pairs are fetch/fetch, store/store,
    // load/load, fetch/store, fetch/load.
    function automatic src_e trig_src(input int unsigned t);
        case (t)
            0, 1, 6, 8: return SRC_FETCH;
            2, 3, 7:    return SRC_STORE;
            default:    return SRC_LOAD;
        endcase
    endfunction

    // Pairs that may never fire while chained (two store triggers).
    function automatic bit pair_chain_banned(input int unsigned g);
        return (trig_src(2 * g) == SRC_STORE) && (trig_src(2 * g + 1) == SRC_STORE);
    endfunction

endpackage

// File: rtl/dtrig_cfg_bank.sv
// Settings storage for all triggers. Takes one write per cycle and ignores
// indices beyond the last trigger. Compare values are not reset: an unarmed
// trigger never looks at its value.
module dtrig_cfg_bank
    import dtrig_pkg::*;
#(
    parameter int unsigned ADDR_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [TRIG_IDX_W-1:0] wr_idx,
    input  logic [1:0]            wr_mtype,
    input  logic                  wr_select,
    input  logic                  wr_timing,
    input  logic                  wr_chain,
    input  logic [ADDR_W-1:0]     wr_value,
    output tctl_t                 ctl_q   [TRIG_NUM],
    output logic [ADDR_W-1:0]     value_q [TRIG_NUM],
    output logic [PAIR_NUM-1:0]   chain_q
);

    for (genvar t = 0; t < TRIG_NUM; t++) begin : g_trig
        logic hit_idx;
        assign hit_idx = wr_valid && (wr_idx == TRIG_IDX_W'(t));

        // Control fields: cleared on reset, replaced on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q[t] <= '{armed: 1'b0, mtype: MT_EQ, sel: 1'b0, timing: 1'b0};
            end else if (hit_idx) begin
                ctl_q[t] <= '{armed: 1'b1, mtype: mtype_e'(wr_mtype),
                              sel: wr_select, timing: wr_timing};
            end
        end

        // Compare value: loaded on an addressed write, no reset needed.
        always_ff @(posedge clk) begin
            if (hit_idx) begin
                value_q[t] <= wr_value;
            end
        end

        if (t % 2 == 0) begin : g_even
            // Chain bit of the pair, kept only from writes to its even member.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[t/2] <= 1'b0;
                end else if (hit_idx) begin
                    chain_q[t/2] <= wr_chain;
                end
            end
        end
    end

endmodule

// File: rtl/dtrig_cmp.sv
// Single-trigger address comparator. Pure combinational. A hit needs an
// armed trigger, address comparison selected and a valid source.
module dtrig_cmp
    import dtrig_pkg::*;
#(
    parameter int unsigned ADDR_W = 64
) (
    input  logic              armed,
    input  mtype_e            mtype,
    input  logic              sel,
    input  logic [ADDR_W-1:0] value,
    input  logic              src_valid,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic rel;

    // Relation chosen by the match type; the reserved code never matches.
    always_comb begin
        case (mtype)
            MT_EQ:   rel = (addr == value);
            MT_GE:   rel = (addr >= value);
            MT_LT:   rel = (addr <  value);
            default: rel = 1'b0;
        endcase
    end

    // Qualify the relation with arming, select and source validity.
    always_comb hit = armed && !sel && src_valid && rel;

endmodule

// File: rtl/dtrig_pair.sv
// Chaining resolution for one pair of triggers. When chained, both fire
// only on a joint hit with equal timing; a banned pair never fires chained.
module dtrig_pair #(
    parameter bit NO_CHAIN = 1'b0
) (
    input  logic hit_lo,
    input  logic hit_hi,
    input  logic tim_lo,
    input  logic tim_hi,
    input  logic chain,
    output logic fire_lo,
    output logic fire_hi
);

    logic joint;

    if (NO_CHAIN) begin : g_banned
        // Chained store/store pair is never allowed to fire.
        always_comb joint = 1'b0;
    end else begin : g_normal
        // Joint hit requires both members and matching timing.
        always_comb joint = hit_lo && hit_hi && (tim_lo == tim_hi);
    end

    // Pick per-member hits or the joint condition by the chain bit.
    always_comb begin
        fire_lo = chain ? joint : hit_lo;
        fire_hi = chain ? joint : hit_hi;
    end

endmodule

// File: rtl/dtrig_eval.sv
// Top of the debug trigger evaluator. Stores trigger settings, compares the
// fetch, load and store addresses, resolves pair chaining and registers the
// fire vector and timing flags. Assumes the fixed ten-trigger layout.
module dtrig_eval
    import dtrig_pkg::*;
#(
    parameter int unsigned ADDR_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr_valid,
    input  logic [TRIG_IDX_W-1:0] cfg_wr_idx,
    input  logic [1:0]            cfg_wr_mtype,
    input  logic                  cfg_wr_select,
    input  logic                  cfg_wr_timing,
    input  logic                  cfg_wr_chain,
    input  logic [ADDR_W-1:0]     cfg_wr_value,
    input  logic                  fetch_valid,
    input  logic [ADDR_W-1:0]     fetch_pc,
    input  logic                  load_valid,
    input  logic [ADDR_W-1:0]     load_addr,
    input  logic                  store_valid,
    input  logic [ADDR_W-1:0]     store_addr,
    output logic [TRIG_NUM-1:0]   fire_vec,
    output logic                  fire_now,
    output logic                  fire_next
);

    tctl_t               ctl_q   [TRIG_NUM];
    logic [ADDR_W-1:0]   value_q [TRIG_NUM];
    logic [PAIR_NUM-1:0] chain_q;
    logic [TRIG_NUM-1:0] hit_w;
    logic [TRIG_NUM-1:0] tim_w;
    logic [TRIG_NUM-1:0] fire_w;
    logic                now_w;
    logic                next_w;

    dtrig_cfg_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (cfg_wr_valid),
        .wr_idx    (cfg_wr_idx),
        .wr_mtype  (cfg_wr_mtype),
        .wr_select (cfg_wr_select),
        .wr_timing (cfg_wr_timing),
        .wr_chain  (cfg_wr_chain),
        .wr_value  (cfg_wr_value),
        .ctl_q     (ctl_q),
        .value_q   (value_q),
        .chain_q   (chain_q)
    );

    for (genvar t = 0; t < TRIG_NUM; t++) begin : g_cmp
        localparam src_e SRC = trig_src(t);
        logic              sv;
        logic [ADDR_W-1:0] sa;

        if (SRC == SRC_FETCH) begin : g_f
            assign sv = fetch_valid;
            assign sa = fetch_pc;
        end else if (SRC == SRC_STORE) begin : g_s
            assign sv = store_valid;
            assign sa = store_addr;
        end else begin : g_l
            assign sv = load_valid;
            assign sa = load_addr;
        end

        dtrig_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .armed     (ctl_q[t].armed),
            .mtype     (ctl_q[t].mtype),
            .sel       (ctl_q[t].sel),
            .value     (value_q[t]),
            .src_valid (sv),
            .addr      (sa),
            .hit       (hit_w[t])
        );

        assign tim_w[t] = ctl_q[t].timing;
    end

    for (genvar g = 0; g < PAIR_NUM; g++) begin : g_pair
        dtrig_pair #(.NO_CHAIN(pair_chain_banned(g))) u_pair (
            .hit_lo  (hit_w[2*g]),
            .hit_hi  (hit_w[2*g+1]),
            .tim_lo  (tim_w[2*g]),
            .tim_hi  (tim_w[2*g+1]),
            .chain   (chain_q[g]),
            .fire_lo (fire_w[2*g]),
            .fire_hi (fire_w[2*g+1])
        );
    end

    // Split fired triggers by requested trap timing.
    always_comb begin
        now_w  = |(fire_w & ~tim_w);
        next_w = |(fire_w &  tim_w);
    end

    // Output register: one cycle from address inputs to reported fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_vec  <= '0;
            fire_now  <= 1'b0;
            fire_next <= 1'b0;
        end else begin
            fire_vec  <= fire_w;
            fire_now  <= now_w;
            fire_next <= next_w;
        end
    end

endmodule

// File: rtl/dtrig_eval_chk.sv
// Assertion checker for dtrig_eval, bound to every instance of it. Relates
// the registered fire outputs to the settings and source valids of the
// cycle before.
module dtrig_eval_chk
    import dtrig_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                fetch_valid,
    input logic                load_valid,
    input logic                store_valid,
    input tctl_t               ctl   [TRIG_NUM],
    input logic [PAIR_NUM-1:0] chain,
    input logic [TRIG_NUM-1:0] fire_vec,
    input logic                fire_now,
    input logic                fire_next
);

    logic [TRIG_NUM-1:0] armed_v, sel_v, tim_v, srcv_v;

    // Flatten settings and per-trigger source valid for use in properties.
    always_comb begin
        for (int t = 0; t < TRIG_NUM; t++) begin
            armed_v[t] = ctl[t].armed;
            sel_v[t]   = ctl[t].sel;
            tim_v[t]   = ctl[t].timing;
            case (trig_src(t))
                SRC_FETCH: srcv_v[t] = fetch_valid;
                SRC_STORE: srcv_v[t] = store_valid;
                default:   srcv_v[t] = load_valid;
            endcase
        end
    end

    a_r9_flag_has_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_now || fire_next) |-> (fire_vec != '0));

    a_r9_fire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_vec != '0) |-> (fire_now || fire_next));

    a_r8_store_pair_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chain[1]) |-> (!fire_vec[2] && !fire_vec[3]));

    for (genvar t = 0; t < TRIG_NUM; t++) begin : g_t
        a_r1_unarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(armed_v[t]) |-> !fire_vec[t]);

        a_r5_select_silent: assert property (@(posedge clk) disable iff (!rst_n)
            $past(sel_v[t]) |-> !fire_vec[t]);

        a_r4_source_gate: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(srcv_v[t]) |-> !fire_vec[t]);
    end

    for (genvar g = 0; g < PAIR_NUM; g++) begin : g_p
        a_r7_pair_agree: assert property (@(posedge clk) disable iff (!rst_n)
            $past(chain[g]) |-> (fire_vec[2*g] == fire_vec[2*g+1]));

        a_r7_timing_split: assert property (@(posedge clk) disable iff (!rst_n)
            $past(chain[g] && (tim_v[2*g] != tim_v[2*g+1]))
            |-> (!fire_vec[2*g] && !fire_vec[2*g+1]));
    end

endmodule

bind dtrig_eval dtrig_eval_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .load_valid  (load_valid),
    .store_valid (store_valid),
    .ctl         (ctl_q),
    .chain       (chain_q),
    .fire_vec    (fire_vec),
    .fire_now    (fire_now),
    .fire_next   (fire_next)
);

// File: tb/test_dtrig_eval.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random traffic, each cycle
// compared with a model of the requirements.
module test_dtrig_eval;

    localparam int AW = 64;
    localparam int NT = 10;
    localparam logic [AW-1:0] BASE = 64'h0000_0040_0000_0100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wv = 1'b0;
    logic [3:0]    widx = '0;
    logic [1:0]    wmt = '0;
    logic          wsel = 1'b0, wtim = 1'b0, wchn = 1'b0;
    logic [AW-1:0] wval = '0;
    logic          fv = 1'b0, lv = 1'b0, sv = 1'b0;
    logic [AW-1:0] fpc = '0, la = '0, sa = '0;
    logic [NT-1:0] fire_vec;
    logic          fire_now, fire_next;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic          m_armed [NT];
    logic [1:0]    m_mt    [NT];
    logic          m_sel   [NT];
    logic          m_tim   [NT];
    logic          m_chn   [NT];
    logic [AW-1:0] m_val   [NT];

    always #2 clk = ~clk;

    dtrig_eval #(.ADDR_W(AW)) i_dtrig_eval (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_valid(wv), .cfg_wr_idx(widx), .cfg_wr_mtype(wmt),
        .cfg_wr_select(wsel), .cfg_wr_timing(wtim), .cfg_wr_chain(wchn),
        .cfg_wr_value(wval),
        .fetch_valid(fv), .fetch_pc(fpc), .load_valid(lv), .load_addr(la),
        .store_valid(sv), .store_addr(sa),
        .fire_vec(fire_vec), .fire_now(fire_now), .fire_next(fire_next)
    );

    // R4 source map: 0 fetch, 1 load, 2 store.
    function automatic int kind(input int t);
        if (t == 0 || t == 1 || t == 6 || t == 8) return 0;
        if (t == 2 || t == 3 || t == 7) return 2;
        return 1;
    endfunction

    function automatic logic [NT+1:0] model_eval();
        logic [NT-1:0] hit, fire;
        logic now_e, next_e;
        for (int t = 0; t < NT; t++) begin
            logic v; logic [AW-1:0] a; logic r;
            case (kind(t))
                0: begin v = fv; a = fpc; end
                1: begin v = lv; a = la; end
                default: begin v = sv; a = sa; end
            endcase
            case (m_mt[t])
                2'd0: r = (a == m_val[t]);
                2'd2: r = (a >= m_val[t]);
                2'd3: r = (a <  m_val[t]);
                default: r = 1'b0;
            endcase
            hit[t] = m_armed[t] && !m_sel[t] && v && r;
        end
        for (int g = 0; g < NT/2; g++) begin
            if (!m_chn[2*g]) begin
                fire[2*g] = hit[2*g]; fire[2*g+1] = hit[2*g+1];
            end else begin
                logic j;
                j = (g != 1) && hit[2*g] && hit[2*g+1] && (m_tim[2*g] == m_tim[2*g+1]);
                fire[2*g] = j; fire[2*g+1] = j;
            end
        end
        now_e = 1'b0; next_e = 1'b0;
        for (int t = 0; t < NT; t++) begin
            if (fire[t] && !m_tim[t]) now_e = 1'b1;
            if (fire[t] &&  m_tim[t]) next_e = 1'b1;
        end
        return {fire, now_e, next_e};
    endfunction

    task automatic check(input string tag, input logic [NT+1:0] e);
        logic [NT+1:0] act;
        act = {fire_vec, fire_now, fire_next};
        n_chk++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: {fire_vec,now,next} actual %b expected %b", tag, act, e);
        end
    endtask

    // One evaluation: inputs already driven at a negedge.
    task automatic cycle(input string tag);
        logic [NT+1:0] e;
        e = model_eval();
        @(posedge clk);
        if (wv && widx < 4'(NT)) begin
            m_armed[widx] = 1'b1; m_mt[widx] = wmt; m_sel[widx] = wsel;
            m_tim[widx] = wtim; m_chn[widx] = wchn; m_val[widx] = wval;
        end
        @(negedge clk);
        check(tag, e);
        wv = 1'b0;
    endtask

    task automatic cfg(input int idx, input int mt, input bit s, input bit tm,
                       input bit c, input logic [AW-1:0] v);
        wv = 1'b1; widx = 4'(idx); wmt = 2'(mt); wsel = s; wtim = tm; wchn = c; wval = v;
    endtask

    task automatic src(input bit f, input logic [AW-1:0] p, input bit l,
                       input logic [AW-1:0] ld, input bit s, input logic [AW-1:0] st);
        fv = f; fpc = p; lv = l; la = ld; sv = s; sa = st;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int t = 0; t < NT; t++) begin
            m_armed[t] = 0; m_mt[t] = 0; m_sel[t] = 0; m_tim[t] = 0; m_chn[t] = 0; m_val[t] = '0;
        end
        src(1, '0, 1, '0, 1, '0);
        repeat (4) @(negedge clk);
        check("R1 in reset", '0);
        rst_n = 1'b1;
        cycle("R1 unconfigured zero addresses");

        // R2: write latency and ignored indices
        cfg(0, 0, 0, 0, 0, BASE); src(1, BASE, 0, '0, 0, '0);
        cycle("R2 same-cycle write");
        cycle("R2 after write eq hit");
        cfg(12, 0, 0, 1, 1, BASE + 1); src(1, BASE + 1, 1, BASE + 1, 1, BASE + 1);
        cycle("R2 idx 12 write");
        cycle("R2 idx 12 no effect");
        cfg(10, 2, 0, 1, 0, '0);
        cycle("R2 idx 10 write");
        cycle("R2 idx 10 no effect");

        // R3: comparison boundaries on trigger 1
        cfg(1, 2, 0, 0, 0, BASE + 4); src(1, BASE + 4, 0, '0, 0, '0);
        cycle("R3 write ge");
        cycle("R3 ge at equal");
        src(1, BASE + 3, 0, '0, 0, '0); cycle("R3 ge below");
        cfg(1, 3, 0, 0, 0, BASE + 4); cycle("R3 write lt");
        cycle("R3 lt below");
        src(1, BASE + 4, 0, '0, 0, '0); cycle("R3 lt at equal");
        cfg(1, 1, 0, 0, 0, BASE + 4); cycle("R3 write type1");
        cycle("R3 type1 never");
        src(1, BASE + 5, 0, '0, 0, '0); cycle("R3 type1 never other");

        // R4: source gating on store trigger 7 and load trigger 9
        cfg(7, 3, 0, 1, 0, BASE + 8); src(0, '0, 0, '0, 0, BASE); cycle("R4 write 7");
        cycle("R4 store invalid");
        src(0, '0, 0, '0, 1, BASE); cycle("R4 store valid");
        cfg(9, 0, 0, 0, 0, BASE + 2); src(1, BASE + 2, 0, BASE + 2, 0, '0); cycle("R4 write 9");
        cycle("R4 fetch does not reach load trigger");
        src(0, '0, 1, BASE + 2, 0, '0); cycle("R4 load valid");

        // R5: select bit
        cfg(8, 0, 1, 0, 0, BASE); src(1, BASE, 0, '0, 0, '0); cycle("R5 write 8 select");
        cycle("R5 select never fires");

        // R6/R7: chaining on pair 0
        cfg(1, 0, 0, 0, 0, BASE); cycle("R7 write 1");
        cfg(0, 0, 0, 0, 1, BASE); cycle("R7 write 0 chained");
        cycle("R7 joint hit");
        cfg(1, 0, 0, 0, 0, BASE + 1); cycle("R7 write 1 apart");
        cycle("R7 lone member");
        cfg(1, 0, 0, 1, 0, BASE); cycle("R7 write 1 timing1");
        cycle("R7 timing mismatch");
        cfg(5, 0, 0, 0, 1, BASE + 6); src(0, '0, 1, BASE + 3, 0, '0); cycle("R6 odd chain write");
        cfg(4, 0, 0, 0, 0, BASE + 3); cycle("R6 write 4 unchained");
        cycle("R6 odd chain ignored");

        // R8: store pair
        cfg(2, 0, 0, 0, 1, BASE); src(0, '0, 0, '0, 1, BASE); cycle("R8 write 2 chained");
        cfg(3, 0, 0, 0, 0, BASE); cycle("R8 write 3");
        cycle("R8 chained store pair silent");
        cfg(2, 0, 0, 0, 0, BASE); cycle("R8 unchain");
        cycle("R8 unchained store pair fires");

        // R9: mixed timing
        cfg(0, 0, 0, 0, 0, BASE); src(1, BASE, 0, '0, 1, BASE); cycle("R9 unchain 0");
        cycle("R9 now and next together");

        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 2 == 0)
                cfg($urandom % 12, $urandom % 4, ($urandom % 8) == 0, $urandom % 2,
                    $urandom % 2, BASE + AW'($urandom % 8));
            src($urandom % 2, BASE + AW'($urandom % 8), $urandom % 2, BASE + AW'($urandom % 8),
                $urandom % 2, BASE + AW'($urandom % 8));
            cycle("R3 R4 R6 R7 R9 R10 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule